// File: doc/BRIEF.md
# Masked Interrupt Pending Controller

This block collects interrupt requests from up to eight peripheral lines into a pending register and drives a single level-sensitive interrupt request toward the processor. Peripherals set pending bits through a post vector and remove them through a clear vector, both sampled on every clock edge. Software controls which lines may reach the processor through an enable mask that is written and read in inverted form: a 1 written to the mask disables the line.

Software reaches the block through a small byte-wide register port. It can program the mask, read the pending status, and acknowledge a single line by writing its number. A second controller's register slots are decoded so that software that expects a cascaded pair sees sensible values. Its mask is stored and read back, but it never raises an interrupt, and its status always reads as zero.

Top module: `masked_irq_ctrl`

## Requirements
- R1: After reset the pending register and the enable vector are zero, `irq` is low, a status read returns 0x00 and a primary mask read returns 0xFF.
- R2: A write to address 0 (primary mask) stores the bitwise complement of `reg_wdata` as the enable vector. A read of address 0 returns the complement of the enable vector, which is the byte last written.
- R3: Each set bit of `post_vec` sets the matching pending bit at the next clock edge. `irq` is high after that edge if any enabled bit is pending.
- R4: Each set bit of `clear_vec` clears the matching pending bit at the next clock edge. `irq` is low after that edge if no enabled bit remains pending.
- R5: When `post_vec` and `clear_vec` set the same bit in one cycle, the clear wins and that pending bit ends at 0.
- R6: A write to address 2 (acknowledge) clears pending bit number `reg_wdata[3:0]` and ignores `reg_wdata[7:4]`. Numbers 8 to 15 clear nothing. The acknowledge also wins over a post to the same bit in that cycle, and `irq` drops if no enabled bit remains pending.
- R7: `irq` is a registered level. It equals the OR of (pending AND enable) as it stands after each clock edge, so a mask write can raise or drop it at the edge of the write.
- R8: A read of address 1 (primary status) returns the pending register as it was before the read edge. All read data appears on `reg_rdata` after the edge that samples `reg_rd` and holds until the next read.
- R9: A write to address 3 (secondary mask) is stored and read back unchanged from address 3, but it never affects `irq`. A read of address 4 (secondary status) returns 0x00.
- R10: Writes to addresses 5 to 7 change nothing. Reads of addresses 2 and 5 to 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| post_vec | input | 8 | Per-line request to set pending bits |
| clear_vec | input | 8 | Per-line request to clear pending bits |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt request to the processor |

## Verification
Every result of this block is due exactly one clock edge after its cause. Post, clear, acknowledge and mask writes all change the pending state, the enable state and `irq` on the edge that samples them, and `reg_rdata` reflects the state from before the read edge. The bench drives each stimulus on a falling edge, waits for the next rising edge, and samples 1 ns later. It then removes the stimulus on the following falling edge, so every check looks at the single edge that the stimulus affected.

// File: rtl/irq_ctrl_pkg.sv
// Package: shared constants and the register address map of the
// masked interrupt controller. Assumes an 8-bit register data path.
package irq_ctrl_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int ACK_W  = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_MASK0 = 3'd0,
        RA_STAT0 = 3'd1,
        RA_ACK0  = 3'd2,
        RA_MASK1 = 3'd3,
        RA_STAT1 = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/irq_regdec.sv
// Module: decodes register writes into mask strobes and a one-hot
// acknowledge vector. Assumes LINES <= 2**ACK_W; acknowledge numbers
// at or above LINES select no line.
module irq_regdec
    import irq_ctrl_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              mask0_we,
    output logic              mask1_we,
    output logic [LINES-1:0]  ack_vec
);
    logic ack_we;

    // Purpose: qualify the write strobe with each decoded address.
    always_comb begin
        mask0_we = reg_wr && (reg_addr == RA_MASK0);
        mask1_we = reg_wr && (reg_addr == RA_MASK1);
        ack_we   = reg_wr && (reg_addr == RA_ACK0);
    end

    // Purpose: turn the low data nibble into a one-hot line select.
    for (genvar i = 0; i < LINES; i++) begin : g_ack
        assign ack_vec[i] = ack_we && (reg_wdata[ACK_W-1:0] == ACK_W'(i));
    end
endmodule

// File: rtl/irq_pending.sv
// Module: the pending register. A post sets a bit, then a clear and an
// acknowledge remove it, so the removal wins within one cycle.
module irq_pending #(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] post_vec,
    input  logic [LINES-1:0] clear_vec,
    input  logic [LINES-1:0] ack_vec,
    output logic [LINES-1:0] pend_d,
    output logic [LINES-1:0] pend_q
);
    // Purpose: next-state per line, set first and removal last.
    for (genvar i = 0; i < LINES; i++) begin : g_bit
        assign pend_d[i] = (pend_q[i] | post_vec[i]) & ~clear_vec[i] & ~ack_vec[i];
    end

    // Purpose: hold the pending state.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/irq_mask_bank.sv
// Module: the enable vectors. The primary mask is stored as the complement
// of the written data. The optional secondary mask is stored the same way
// but drives no interrupt.
module irq_mask_bank
    import irq_ctrl_pkg::*;
#(
    parameter int LINES  = 8,
    parameter bit SECOND = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask0_we,
    input  logic              mask1_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [LINES-1:0]  en0_d,
    output logic [LINES-1:0]  en0_q,
    output logic [LINES-1:0]  en1_q
);
    // Purpose: next primary enable, taken from an inverted write.
    always_comb begin
        en0_d = mask0_we ? ~wdata[LINES-1:0] : en0_q;
    end

    // Purpose: hold the primary enable.
    always_ff @(posedge clk) begin
        if (!rst_n) en0_q <= '0;
        else        en0_q <= en0_d;
    end

    if (SECOND) begin : g_second
        // Purpose: hold the secondary enable for read-back only.
        always_ff @(posedge clk) begin
            if (!rst_n)        en1_q <= '0;
            else if (mask1_we) en1_q <= ~wdata[LINES-1:0];
        end
    end else begin : g_no_second
        assign en1_q = '0;
    end
endmodule

// File: rtl/irq_level.sv
// Module: the registered interrupt level, computed from the next pending
// and enable state so that it moves on the same edge as they do.
module irq_level #(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pend_d,
    input  logic [LINES-1:0] en_d,
    output logic             irq_q
);
    // Purpose: raise while any enabled line is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(pend_d & en_d);
    end
endmodule

// File: rtl/masked_irq_ctrl.sv
// Module: top of the masked interrupt pending controller. It ties together
// decode, pending state, the mask bank and the level output, and registers
// the read data. Assumes LINES == DATA_W so that each register byte maps
// one bit per line.
module masked_irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  post_vec,
    input  logic [LINES-1:0]  clear_vec,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic             mask0_we, mask1_we;
    logic [LINES-1:0] ack_vec, pend_d, pend_q, en0_d, en0_q, en1_q;
    logic [DATA_W-1:0] rd_mux;

    irq_regdec #(.LINES(LINES)) u_dec (
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .mask0_we(mask0_we), .mask1_we(mask1_we), .ack_vec(ack_vec)
    );

    irq_pending #(.LINES(LINES)) u_pend (
        .clk(clk), .rst_n(rst_n), .post_vec(post_vec), .clear_vec(clear_vec),
        .ack_vec(ack_vec), .pend_d(pend_d), .pend_q(pend_q)
    );

    irq_mask_bank #(.LINES(LINES), .SECOND(1'b1)) u_mask (
        .clk(clk), .rst_n(rst_n), .mask0_we(mask0_we), .mask1_we(mask1_we),
        .wdata(reg_wdata), .en0_d(en0_d), .en0_q(en0_q), .en1_q(en1_q)
    );

    irq_level #(.LINES(LINES)) u_lvl (
        .clk(clk), .rst_n(rst_n), .pend_d(pend_d), .en_d(en0_d), .irq_q(irq)
    );

    // Purpose: select the read value from the current register state.
    always_comb begin
        case (reg_addr)
            RA_MASK0: rd_mux = DATA_W'(~en0_q);
            RA_STAT0: rd_mux = DATA_W'(pend_q);
            RA_MASK1: rd_mux = DATA_W'(~en1_q);
            default:  rd_mux = '0;
        endcase
    end

    // Purpose: register read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end
endmodule

// File: rtl/masked_irq_ctrl_chk.sv
// Module: assertion checker for masked_irq_ctrl, attached through bind.
module masked_irq_ctrl_chk
    import irq_ctrl_pkg::*;
#(
    parameter int LINES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LINES-1:0]  post_vec,
    input logic [LINES-1:0]  clear_vec,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq,
    input logic [LINES-1:0]  pend,
    input logic [LINES-1:0]  en
);
    // R2: the enable vector is the inverse of the mask byte written.
    assert_mask_inv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_MASK0) |=> (en == ~$past(reg_wdata[LINES-1:0])));

    // R3: posted bits are pending next cycle unless cleared or acknowledged.
    assert_post_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == RA_ACK0) |=>
        ((pend & $past(post_vec & ~clear_vec)) == $past(post_vec & ~clear_vec)));

    // R4: cleared bits are gone next cycle (also R5 when a post collides).
    assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & $past(clear_vec)) == '0));

    // R6: an acknowledged line number is no longer pending.
    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_ACK0 && reg_wdata[ACK_W-1:0] < ACK_W'(LINES)) |=>
        (((pend >> $past(reg_wdata[ACK_W-1:0])) & LINES'(1)) == '0));

    // R7: the output level tracks enabled pending state.
    assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == |(pend & en)));

    // R9: the secondary status always reads as zero.
    assert_stat1_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == RA_STAT1) |=> (reg_rdata == '0));
endmodule

bind masked_irq_ctrl masked_irq_ctrl_chk #(.LINES(LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .post_vec(post_vec), .clear_vec(clear_vec),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .pend(pend_q), .en(en0_q)
);

// File: tb/sim_masked_irq_ctrl.sv
module sim_masked_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] post_vec = '0, clear_vec = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_chk = 0, n_fail = 0;
    logic       s_irq;
    logic [7:0] s_data;

    masked_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .post_vec(post_vec), .clear_vec(clear_vec),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1 s_irq = irq;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(posedge clk); #1 s_data = reg_rdata; s_irq = irq;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic pulse(logic [7:0] p, logic [7:0] c);
        @(negedge clk); post_vec = p; clear_vec = c;
        @(posedge clk); #1 s_irq = irq;
        @(negedge clk); post_vec = '0; clear_vec = '0;
    endtask

    task automatic t_reset;
        check("R1 irq", {7'd0, irq}, 8'h00);
        rd(3'd1); check("R1 status", s_data, 8'h00);
        rd(3'd0); check("R1 mask", s_data, 8'hFF);
    endtask

    task automatic t_mask_rw;
        wr(3'd0, 8'hA5); rd(3'd0); check("R2 mask readback", s_data, 8'hA5);
        wr(3'd0, 8'hFF);
    endtask

    task automatic t_post_gate;
        pulse(8'h10, 8'h00); check("R3 masked post irq", {7'd0, s_irq}, 8'h00);
        rd(3'd1); check("R8 status", s_data, 8'h10);
        wr(3'd0, 8'hEF); check("R7 unmask raises", {7'd0, s_irq}, 8'h01);
        wr(3'd0, 8'hFF); check("R7 mask drops", {7'd0, s_irq}, 8'h00);
        wr(3'd0, 8'h00);
        pulse(8'h03, 8'h00); check("R3 enabled post irq", {7'd0, s_irq}, 8'h01);
    endtask

    task automatic t_clear;
        pulse(8'h00, 8'h10); check("R4 partial clear irq", {7'd0, s_irq}, 8'h01);
        rd(3'd1); check("R4 status", s_data, 8'h03);
        pulse(8'h00, 8'h03); check("R4 irq falls", {7'd0, s_irq}, 8'h00);
        rd(3'd1); check("R4 status empty", s_data, 8'h00);
    endtask

    task automatic t_same_cycle;
        pulse(8'h81, 8'h01); check("R5 irq", {7'd0, s_irq}, 8'h01);
        rd(3'd1); check("R5 clear wins", s_data, 8'h80);
    endtask

    task automatic t_ack;
        wr(3'd2, 8'h07); check("R6 ack drops irq", {7'd0, s_irq}, 8'h00);
        pulse(8'h04, 8'h00);
        wr(3'd2, 8'h0A); check("R6 ack out of range irq", {7'd0, s_irq}, 8'h01);
        rd(3'd1); check("R6 ack out of range", s_data, 8'h04);
        wr(3'd2, 8'hF2); check("R6 upper nibble ignored", {7'd0, s_irq}, 8'h00);
        rd(3'd1); check("R6 status after ack", s_data, 8'h00);
    endtask

    task automatic t_secondary;
        wr(3'd0, 8'hFF); wr(3'd3, 8'h00);
        pulse(8'h01, 8'h00); check("R9 secondary mask no irq", {7'd0, s_irq}, 8'h00);
        rd(3'd3); check("R9 secondary mask readback", s_data, 8'h00);
        wr(3'd3, 8'h3C); rd(3'd3); check("R9 secondary mask 3C", s_data, 8'h3C);
        rd(3'd4); check("R9 secondary status", s_data, 8'h00);
    endtask

    task automatic t_unmapped;
        wr(3'd5, 8'h00); check("R10 write ignored irq", {7'd0, s_irq}, 8'h00);
        wr(3'd7, 8'h00);
        rd(3'd0); check("R10 mask kept", s_data, 8'hFF);
        rd(3'd1); check("R10 status kept", s_data, 8'h01);
        rd(3'd6); check("R10 unmapped read", s_data, 8'h00);
        rd(3'd2); check("R10 ack read", s_data, 8'h00);
    endtask

    initial begin : watchdog
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset;
        t_mask_rw;
        t_post_gate;
        t_clear;
        t_same_cycle;
        t_ack;
        t_secondary;
        t_unmapped;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule